// File: doc/BRIEF.md
# UART Interrupt Flag Controller

This block keeps the interrupt status of a UART receiver and transmitter in one place. The receiver hands it single-cycle event pulses for a frame error, a parity error, each received BREAK frame, the end of a BREAK run and a receive timeout. The transmit and receive FIFOs hand it their current entry counts, which it compares against two programmable levels. Each event or level condition sets a sticky flag. Software clears a flag by writing 1 to its bit.

Each flag has an enable bit at the same position in a second register. The interrupt output is the OR of all enabled flags, taken through one register stage. Both registers sit behind a plain address / write-enable / write-data / read-data port. Reads are combinational.

A BREAK run produces two separate flags, one on its first frame and one at its end. The two FIFO threshold flags are level-driven. Clearing one of them has no lasting effect while its FIFO condition still holds.

Top module: `uart_irq_flags`

## Requirements
- R1: After reset the flag register, the enable register and `irq_o` are all 0.
- R2: Word address 0 selects the enable register and address 1 selects the flag register. Any other address reads 0, and a write to it changes nothing. Flag and enable bits 2, 3 and 10 and above always read 0.
- R3: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves the flag unchanged. A flag never drops without such a write.
- R4: When a set condition and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A frame-error pulse sets flag bit 0. A parity-error pulse sets bit 1. A receive-timeout pulse sets bit 8.
- R6: Flag bit 6 (TX threshold) is set in every cycle in which the TX entry count is less than or equal to the TX level. A clear has no lasting effect until that condition ends.
- R7: Flag bit 4 (RX threshold) is set in every cycle in which the RX entry count is greater than or equal to the RX level. A clear has no lasting effect until that condition ends.
- R8: Flag bit 5 (TX almost empty) is set in the cycle in which the TX entry count changes to exactly 1. A count that stays at 1 does not set it again.
- R9: Flag bit 7 is set by a BREAK-frame pulse that starts a run. Further BREAK frames in the same run do not set it.
- R10: Flag bit 9 is set by a break-end pulse that closes a run. A break-end pulse outside a run has no effect.
- R11: The enable register holds bits 0, 1 and 4 to 9 as read/write bits.
- R12: `irq_o` equals the OR of (flag AND enable), taken from the previous cycle's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_frame_err_i | input | 1 | Frame error event pulse |
| rx_parity_err_i | input | 1 | Parity error event pulse |
| rx_break_frame_i | input | 1 | Pulse for each received BREAK frame |
| rx_break_done_i | input | 1 | Pulse when a BREAK run ends |
| rx_timeout_i | input | 1 | Receive timeout event pulse |
| tx_count_i | input | CW | TX FIFO entry count |
| rx_count_i | input | CW | RX FIFO entry count |
| tx_level_i | input | CW | TX threshold level |
| rx_level_i | input | CW | RX threshold level |
| reg_addr_i | input | AW | Register word address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume three things about the inputs. A BREAK-frame pulse and a break-end pulse never arrive in the same cycle. The FIFO counts never exceed the depth. The counts and levels are stable within a cycle. The stimulus keeps within these assumptions: the break inputs are drawn from one random value, so at most one of them is high in a cycle, and counts are drawn between 0 and the depth. The FIFO levels are driven only between clock edges.

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_frame_err_i,
  input  logic          rx_parity_err_i,
  input  logic          rx_break_frame_i,
  input  logic          rx_break_done_i,
  input  logic          rx_timeout_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_level_i,
  input  logic [CW-1:0] rx_level_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int NF        = 10;
  localparam int EN_ADDR   = 0;
  localparam int FLAG_ADDR = 1;
  localparam logic [NF-1:0] LIVE = 10'h3F3;

  logic [NF-1:0] flag_q, en_q, set_v, clr_v;
  logic          brk_run_q, tx_one_q, irq_q;
  logic          wr_flag, wr_en, unused_hi;

  assign wr_flag   = reg_we_i && (reg_addr_i == AW'(FLAG_ADDR));
  assign wr_en     = reg_we_i && (reg_addr_i == AW'(EN_ADDR));
  assign clr_v     = wr_flag ? reg_wdata_i[NF-1:0] : '0;
  assign unused_hi = ^reg_wdata_i[DW-1:NF];

  always_comb begin
    set_v    = '0;
    set_v[0] = rx_frame_err_i;
    set_v[1] = rx_parity_err_i;
    set_v[4] = rx_count_i >= rx_level_i;
    set_v[5] = (tx_count_i == CW'(1)) && !tx_one_q;
    set_v[6] = tx_count_i <= tx_level_i;
    set_v[7] = rx_break_frame_i && !brk_run_q;
    set_v[8] = rx_timeout_i;
    set_v[9] = rx_break_done_i && brk_run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= '0;
      en_q      <= '0;
      brk_run_q <= 1'b0;
      tx_one_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      flag_q   <= ((flag_q & ~clr_v) | set_v) & LIVE;
      tx_one_q <= tx_count_i == CW'(1);
      irq_q    <= |(flag_q & en_q);
      if (wr_en) en_q <= reg_wdata_i[NF-1:0] & LIVE;
      if (rx_break_frame_i) brk_run_q <= 1'b1;
      else if (rx_break_done_i) brk_run_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(FLAG_ADDR)) reg_rdata_o = DW'(flag_q);
    else if (reg_addr_i == AW'(EN_ADDR)) reg_rdata_o = DW'(en_q);
  end

  assign irq_o = irq_q;

  p_brk_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_break_frame_i && rx_break_done_i));
  p_count_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(tx_count_i) <= DEPTH) && (int'(rx_count_i) <= DEPTH));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flag && reg_wdata_i[8] && !rx_timeout_i) |=> !flag_q[8]);
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_err_i |=> flag_q[0]);
  p_tx_thr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i <= tx_level_i) |=> flag_q[6]);
  p_rx_thr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i >= rx_level_i) |=> flag_q[4]);
  p_brk_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_frame_i && !brk_run_q) |=> (flag_q[7] && brk_run_q));
  p_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(flag_q & en_q) |=> irq_o);
  p_no_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_q & en_q)) |=> !irq_o);
endmodule

// File: tb/uart_irq_flags_tb_top.sv
module uart_irq_flags_tb_top;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fe = 0, pe = 0, bf = 0, bd = 0, to = 0;
  logic [CW-1:0] txc = 4, rxc = 0, txl = 0, rxl = 4;
  logic [3:0] addr = 1;
  logic we = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  uart_irq_flags #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_frame_err_i(fe), .rx_parity_err_i(pe),
    .rx_break_frame_i(bf), .rx_break_done_i(bd), .rx_timeout_i(to),
    .tx_count_i(txc), .rx_count_i(rxc), .tx_level_i(txl), .rx_level_i(rxl),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  bit [9:0] m_flag, m_en;
  bit m_run, m_one, m_irq;

  always @(posedge clk) begin
    bit [9:0] s, c;
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_run = 0; m_one = 0; m_irq = 0;
    end else begin
      s = 0;
      if (fe) s[0] = 1;
      if (pe) s[1] = 1;
      if (int'(rxc) >= int'(rxl)) s[4] = 1;
      if (int'(txc) == 1 && !m_one) s[5] = 1;
      if (int'(txc) <= int'(txl)) s[6] = 1;
      if (bf && !m_run) s[7] = 1;
      if (to) s[8] = 1;
      if (bd && m_run) s[9] = 1;
      c = (we && addr == 1) ? wdata[9:0] : 10'h0;
      m_irq = |(m_flag & m_en);
      if (we && addr == 0) m_en = wdata[9:0] & 10'h3F3;
      m_flag = ((m_flag & ~c) | s) & 10'h3F3;
      m_one = int'(txc) == 1;
      if (bf) m_run = 1; else if (bd) m_run = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (chk_on) begin
      chk("R12 irq", 32'(irq), 32'(m_irq));
      chk("R2/R3 read", rdata, addr == 1 ? 32'(m_flag) : addr == 0 ? 32'(m_en) : 32'h0);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0; addr = 1;
  endtask
  task automatic bits(string tag, logic [31:0] mask, logic [31:0] exp);
    #1 chk(tag, rdata & mask, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; chk_on = 1;
    tick();
    bits("R1 flags", 32'hFFFFFFFF, 0);
    chk("R1 irq", 32'(irq), 0);
    addr = 0; bits("R1 enable", 32'hFFFFFFFF, 0); addr = 1;

    fe = 1; tick(); fe = 0;
    pe = 1; tick(); pe = 0;
    to = 1; tick(); to = 0;
    bits("R5 events", 32'h3FF, 32'h103);
    wr(1, 0); bits("R3 write zero", 32'h3FF, 32'h103);
    wr(1, 1); bits("R3 clear bit0", 32'h3FF, 32'h102);
    fe = 1; wr(1, 1); fe = 0; bits("R4 set wins", 32'h1, 32'h1);

    wr(2, 32'hFFFFFFFF); bits("R2 bad addr write", 32'h3FF, 32'h103);
    addr = 2; bits("R2 bad addr read", 32'hFFFFFFFF, 0); addr = 1;
    wr(0, 32'hFFFFFFFF);
    addr = 0; bits("R11 enable bits", 32'hFFFFFFFF, 32'h3F3); addr = 1;
    wr(1, 32'h3FF); tick();
    bits("R2 flags clear", 32'hFFFFFFFF, 0);
    chk("R12 idle", 32'(irq), 0);
    fe = 1; tick(); fe = 0;
    #1 chk("R12 lag", 32'(irq), 0);
    tick(); #1 chk("R12 raised", 32'(irq), 1);
    wr(0, 0); tick(); #1 chk("R12 disabled", 32'(irq), 0);
    wr(1, 32'h3FF);

    txl = 4; tick(); bits("R6 set", 32'h40, 32'h40);
    wr(1, 32'h40); bits("R6 reassert", 32'h40, 32'h40);
    txc = 5; wr(1, 32'h40); bits("R6 cleared", 32'h40, 0);
    tick(); bits("R6 stays clear", 32'h40, 0);

    rxc = 4; tick(); bits("R7 set", 32'h10, 32'h10);
    wr(1, 32'h10); bits("R7 reassert", 32'h10, 32'h10);
    rxc = 3; wr(1, 32'h10); bits("R7 cleared", 32'h10, 0);

    txl = 0; txc = 1; tick(); bits("R8 set", 32'h20, 32'h20);
    wr(1, 32'h20); bits("R8 no resets at 1", 32'h20, 0);
    txc = 2; tick(); txc = 1; tick(); bits("R8 set again", 32'h20, 32'h20);

    wr(1, 32'h3FF);
    bd = 1; tick(); bd = 0; bits("R10 end outside run", 32'h200, 0);
    bf = 1; tick(); bf = 0; bits("R9 first frame", 32'h280, 32'h80);
    wr(1, 32'h80);
    bf = 1; tick(); bf = 0; bits("R9 later frame", 32'h80, 0);
    bd = 1; tick(); bd = 0; bits("R10 run end", 32'h280, 32'h200);
    bf = 1; tick(); bf = 0; bits("R9 new run", 32'h80, 32'h80);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      bf = (r == 0); bd = (r == 1);
      fe = ($urandom_range(0, 9) == 0);
      pe = ($urandom_range(0, 9) == 0);
      to = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 3) == 0) txc = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 3) == 0) rxc = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 31) == 0) txl = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 31) == 0) rxl = CW'($urandom_range(1, DEPTH));
      addr = 4'($urandom_range(0, 3));
      we = ($urandom_range(0, 5) == 0);
      wdata = $urandom();
      tick();
    end
    we = 0; bf = 0; bd = 0; fe = 0; pe = 0; to = 0; addr = 1;
    tick(); tick();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule